// File: doc/BRIEF.md
# Selectable Infrared Carrier Generator

This block produces the modulated output line of an infrared transmitter from the system clock. A three-bit select code picks one of six carrier periods: 8, 16, 64, 96, 128 or 192 clocks. It can also pick a mode with no carrier, in which the line is held steadily high. A transmit-enable input gates the carrier onto the active-high output. An active-low indicator output is low for as long as transmission is enabled, so an LED can show that a burst is being sent.

The core is a three-state machine. The states are:

- `ST_IDLE`: output low, indicator high.
- `ST_BURST`: a period counter runs and the output is high for the first third of each period.
- `ST_STEADY`: output constantly high.

The transitions are:

- Start: `ST_IDLE` goes to `ST_BURST` or to `ST_STEADY` when enable is sampled high, depending on the code.
- Stop: `ST_BURST` or `ST_STEADY` goes to `ST_IDLE` when enable is sampled low.
- Boundary reload: `ST_BURST` goes to `ST_BURST` or to `ST_STEADY` at the last clock of a period, taking the code present then.
- Resume: `ST_STEADY` goes to `ST_BURST` as soon as a carrier code is sampled.

The period and the high length are latched on every transition that loads the code. A change of code therefore never cuts a pulse short.

Top module: `ircar_top`

## Requirements
- R1: While reset is asserted, and after it until enable is first sampled high, `rem_out` is 0 and `led_n` is 1.
- R2: Codes 0, 1, 2, 3, 4 and 5 select carrier periods of 8, 16, 64, 96, 128 and 192 clocks. With enable held high, `rem_out` repeats with exactly that period.
- R3: In each carrier period `rem_out` is high for floor(period/3) clocks (2, 5, 21, 32, 42, 64) and then low for the rest of the period.
- R4: Let edge 0 be the first clock edge at which enable is sampled high from idle. `rem_out` is high from just after edge 0, and that first pulse has its full width.
- R5: Codes 6 and 7 select no carrier. When transmission starts in one of these codes, `rem_out` is high from just after edge 0 for as long as enable stays high.
- R6: After an edge that samples enable low, `rem_out` is 0 and `led_n` is 1. While idle, changes of `sel` have no effect on either output.
- R7: After an edge that samples enable high, `led_n` is 0. `rem_out` is never 1 while `led_n` is 1.
- R8: A code change while a carrier is running takes effect at the next period boundary. The current period completes with the old period and high length, and the new carrier (or the steady level) starts with a full period.
- R9: In no-carrier mode, sampling a carrier code starts that carrier at once with a fresh full period, beginning with its high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable, sampled on the rising clock edge |
| sel | input | 3 | Carrier select code (0..5 carrier, 6..7 no carrier) |
| rem_out | output | 1 | Modulated infrared output, active high |
| led_n | output | 1 | Transmit indicator, active low |

## Verification
The assertions assume the following about the inputs:

- `tx_en` and `sel` change away from the rising edge.
- `tx_en` is held low throughout reset.

The bench meets both assumptions: it drives every input on the falling edge and keeps enable low until reset is released.

The minimum-pulse check treats a fall of `rem_out` with enable still high as a period boundary. It can do so only because enable is the only input that may end a pulse early, and the bench always drops enable explicitly before a new transmission.

// File: rtl/ircar_pkg.sv
package ircar_pkg;

    localparam int unsigned SEL_W   = 3;
    localparam int unsigned MAX_PER = 192;
    localparam int unsigned CNT_W   = $clog2(MAX_PER);

    typedef logic [SEL_W-1:0] ircar_sel_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BURST  = 2'd1,
        ST_STEADY = 2'd2
    } ircar_state_t;

    // Carrier period in clocks for a select code; 0 means no carrier.
    function automatic int unsigned period_of(input ircar_sel_t code);
        int unsigned p;
        case (code)
            3'd0:    p = 8;
            3'd1:    p = 16;
            3'd2:    p = 64;
            3'd3:    p = 96;
            3'd4:    p = 128;
            3'd5:    p = 192;
            default: p = 0;
        endcase
        return p;
    endfunction

    function automatic logic is_carrier(input ircar_sel_t code);
        return period_of(code) != 0;
    endfunction

    // High phase: one third of the period, rounded down.
    function automatic int unsigned high_of(input ircar_sel_t code);
        return period_of(code) / 3;
    endfunction

endpackage

// File: rtl/ircar_div.sv
module ircar_div #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] per_m1,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    assign wrap = run && (cnt == per_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ircar_ctrl.sv
module ircar_ctrl
    import ircar_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  ircar_sel_t    sel,
    input  logic          wrap,
    output ircar_state_t  state,
    output logic [CW-1:0] per_m1,
    output logic [CW-1:0] high_len
);

    ircar_state_t nxt;
    logic         load;

    // Transition process
    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (tx_en) begin
                    load = 1'b1;
                    nxt  = is_carrier(sel) ? ST_BURST : ST_STEADY;
                end
            end
            ST_BURST: begin
                if (!tx_en) begin
                    nxt = ST_IDLE;
                end else if (wrap) begin
                    load = 1'b1;
                    nxt  = is_carrier(sel) ? ST_BURST : ST_STEADY;
                end
            end
            ST_STEADY: begin
                if (!tx_en) begin
                    nxt = ST_IDLE;
                end else if (is_carrier(sel)) begin
                    load = 1'b1;
                    nxt  = ST_BURST;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Latched carrier shape, loaded only on a start, a boundary or a resume
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_m1   <= '0;
            high_len <= '0;
        end else if (load && is_carrier(sel)) begin
            per_m1   <= CW'(period_of(sel) - 1);
            high_len <= CW'(high_of(sel));
        end
    end

endmodule

// File: rtl/ircar_top.sv
module ircar_top
    import ircar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [SEL_W-1:0] sel,
    output logic             rem_out,
    output logic             led_n
);

    ircar_state_t     state;
    logic [CNT_W-1:0] per_m1;
    logic [CNT_W-1:0] high_len;
    logic [CNT_W-1:0] cnt;
    logic             wrap;

    ircar_ctrl #(
        .CW(CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .sel      (sel),
        .wrap     (wrap),
        .state    (state),
        .per_m1   (per_m1),
        .high_len (high_len)
    );

    ircar_div #(
        .CNT_W(CNT_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_BURST),
        .per_m1 (per_m1),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    // Output process
    always_comb begin
        rem_out = 1'b0;
        led_n   = 1'b1;
        unique case (state)
            ST_IDLE: begin
                rem_out = 1'b0;
                led_n   = 1'b1;
            end
            ST_BURST: begin
                rem_out = (cnt < high_len);
                led_n   = 1'b0;
            end
            ST_STEADY: begin
                rem_out = 1'b1;
                led_n   = 1'b0;
            end
            default: begin
                rem_out = 1'b0;
                led_n   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ircar_chk.sv
module ircar_chk
    import ircar_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tx_en,
    input logic [SEL_W-1:0] sel,
    input logic             rem_out,
    input logic             led_n
);

    localparam int unsigned MIN_HIGH = 2;

    logic [7:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (rem_out) begin
            hi_run <= (hi_run == 8'hFF) ? hi_run : hi_run + 1'b1;
        end else begin
            hi_run <= '0;
        end
    end

    assert_off_when_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tx_en) |-> (!rem_out && led_n));

    assert_led_on_when_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_en) |-> !led_n);

    assert_rem_implies_led_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rem_out |-> !led_n);

    assert_min_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rem_out) && $past(tx_en)) |-> (hi_run >= 8'(MIN_HIGH)));

    assert_start_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_en) && !$past(led_n, 1) == 1'b0 && $fell(led_n)) |-> rem_out);

endmodule

bind ircar_top ircar_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .sel     (sel),
    .rem_out (rem_out),
    .led_n   (led_n)
);

// File: tb/tb_ircar_top.sv
module tb_ircar_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_en;
    logic [2:0] sel;
    logic       rem_out;
    logic       led_n;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ircar_top dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .sel     (sel),
        .rem_out (rem_out),
        .led_n   (led_n)
    );

    function automatic int bper(input int c);
        case (c)
            0: return 8;
            1: return 16;
            2: return 64;
            3: return 96;
            4: return 128;
            5: return 192;
            default: return 0;
        endcase
    endfunction

    function automatic int patt(input int c, input int j);
        int p;
        p = bper(c);
        if (p == 0) return 1;
        return ((j % p) < (p / 3)) ? 1 : 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Enable with code c0, optionally switch to c1 after cycle sw_at.
    task automatic run_seq(input int c0, input int c1, input int sw_at, input int len, input string req);
        int b;
        int e;
        @(negedge clk);
        sel   = 3'(c0);
        tx_en = 1'b1;
        if (sw_at < 0) b = len + 1;
        else if (bper(c0) != 0) b = (sw_at / bper(c0) + 1) * bper(c0);
        else b = sw_at + 1;
        for (int i = 0; i < len; i++) begin
            @(posedge clk);
            @(negedge clk);
            e = (i < b) ? patt(c0, i) : patt(c1, i - b);
            check(rem_out == e[0], req, int'(rem_out), e);
            check(led_n == 1'b0, "R7", int'(led_n), 0);
            if (i == sw_at) sel = 3'(c1);
        end
    endtask

    task automatic stop_check();
        @(negedge clk);
        tx_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(rem_out == 1'b0, "R6", int'(rem_out), 0);
            check(led_n == 1'b1, "R6", int'(led_n), 1);
            sel = 3'(k * 3);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        tx_en = 1'b0;
        sel   = 3'd0;
        repeat (3) @(negedge clk);
        check(rem_out == 1'b0, "R1", int'(rem_out), 0);
        check(led_n == 1'b1, "R1", int'(led_n), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(rem_out == 1'b0, "R1", int'(rem_out), 0);
        check(led_n == 1'b1, "R1", int'(led_n), 1);

        // R2 R3 R4 R5: every code from idle
        for (int c = 0; c < 8; c++) begin
            if (bper(c) != 0) run_seq(c, c, -1, 2 * bper(c) + 2, "R2");
            else run_seq(c, c, -1, 12, "R5");
            stop_check();
        end

        // R4: restart in the middle of a low phase gives a full first pulse
        run_seq(1, 1, -1, 9, "R4");
        stop_check();
        run_seq(1, 1, -1, 20, "R4");
        stop_check();

        // R8: mid-burst code changes
        run_seq(0, 1, 2, 40, "R8");
        stop_check();
        run_seq(0, 6, 2, 20, "R8");
        stop_check();
        run_seq(5, 0, 10, 220, "R8");
        stop_check();
        run_seq(1, 7, 20, 40, "R8");
        stop_check();

        // R9: no-carrier to carrier
        run_seq(6, 2, 2, 80, "R9");
        stop_check();
        run_seq(7, 0, 4, 30, "R9");
        stop_check();

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule